// File: doc/BRIEF.md
# Arbiter Slot-Table Builder

This engine computes the contents of a memory arbiter's slot table. The table has a fixed number of time slots, 64 by default, and each slot names the client that owns it. The engine reads three things: a packed vector of per-client reserved slot counts, a per-client active mask, and a budget of spare slots. These are captured when a start pulse arrives. The engine then places every client's reservations at evenly spaced positions. Each active client that asked for nothing gets one spare slot, for as long as the budget lasts. Any slot still empty is then handed out round-robin across the active clients.

When the table is complete, the engine streams it out in ascending slot order, one entry per cycle, on a write port (`wr_en`, `wr_slot`, `wr_client`). It then raises `done` for one cycle. A surrounding controller copies these writes into the live arbiter table. Converting bandwidth figures into slot counts, and deciding whether a request fits, are handled outside this block.

Top module: `slot_table_builder`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all low.
- R2: Clients are processed in ascending index order. The request of client c sits in `req_cnt[c*RW +: RW]`. A client with request N > 0 uses a spacing of NSLOTS/N (integer division). Its walk starts at slot 0. An owned slot advances the walk by one. A free slot is taken, and the walk then advances by the spacing. The walk stops at NSLOTS. This applies whether or not the client is active.
- R3: An active client with a zero request takes the first free slot, but only while the spare budget captured at start is above zero. Each such slot lowers the budget by one. A zero budget gives these clients nothing in this pass.
- R4: An inactive client with a zero request receives no slot in the reservation pass. In the fill pass it is never chosen while some other client is active.
- R5: Every slot left free after the reservation pass is given to the first active client found at or after a round-robin pointer. The pointer starts at client 0 for each run. After each such fill it moves to one past the chosen client, modulo NCLIENTS.
- R6: When no client is active, a free slot receives the client the round-robin pointer names. The pointer still advances by one.
- R7: Each run writes exactly NSLOTS entries, on consecutive cycles and in ascending slot order starting at 0. Slots filled in the reservation pass are included. Every written client index is below NCLIENTS.
- R8: `done` is high for exactly one cycle, in the cycle after the write of the last slot. `busy` is low in that cycle.
- R9: A start pulse that arrives while `busy` is high is ignored. Changes on the request inputs during a run have no effect on the table.
- R10: Each run begins from an entirely free table. Nothing from an earlier run carries over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; captures the inputs below |
| req_cnt | input | NCLIENTS*RW | Reserved slot count per client, client c at bits c*RW upward |
| active | input | NCLIENTS | Active flag per client, bit c for client c |
| spare | input | SPW | Budget of spare slots for zero-request active clients |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last table write |
| wr_en | output | 1 | Table entry valid this cycle |
| wr_slot | output | SLW | Slot index of the entry |
| wr_client | output | CLW | Client that owns the slot |

## Verification
The table is held only inside the engine, so faults in several places all reach the streamed entries. A wrong walk cursor, a stale free flag or an off-by-one spare budget shows up as a wrong owner at a specific slot. A misstepped round-robin pointer shows up the same way. These errors appear within the one run that follows the start pulse, no later than the 64th write. The bench recomputes each table from the requirements under swept request, mask and budget patterns, and compares every slot. A faulty sequencer instead shows up as a missing or out-of-order write, or as a `done` pulse that does not follow slot 63 directly.

// File: rtl/slot_table_builder.sv
module slot_table_builder #(
  parameter int NSLOTS = 64,
  parameter int NCLIENTS = 15,
  parameter int RW = $clog2(NSLOTS + 1),
  localparam int CLW = (NCLIENTS > 1) ? $clog2(NCLIENTS) : 1,
  localparam int SLW = $clog2(NSLOTS),
  localparam int SPW = $clog2(NSLOTS + 1),
  localparam int PW = $clog2(2 * NSLOTS) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NCLIENTS*RW-1:0] req_cnt,
  input  logic [NCLIENTS-1:0]    active,
  input  logic [SPW-1:0]         spare,
  output logic                   busy,
  output logic                   done,
  output logic                   wr_en,
  output logic [SLW-1:0]         wr_slot,
  output logic [CLW-1:0]         wr_client
);

  typedef enum logic [1:0] {S_IDLE, S_RES, S_FILL, S_FIN} st_t;

  st_t                   st;
  logic [NCLIENTS*RW-1:0] req_q;
  logic [NCLIENTS-1:0]   act_q;
  logic [SPW-1:0]        spare_q;
  logic [CLW-1:0]        cl, rr, pick, rr_next;
  logic [PW-1:0]         pos, step;
  logic [SLW-1:0]        slot, pos_slot;
  logic [NSLOTS-1:0]     owned;
  logic [CLW-1:0]        tbl [NSLOTS];
  logic [RW-1:0]         cur_req;
  logic                  zero_req, skip, walk_end, last_cl, take;

  assign busy     = (st != S_IDLE);
  assign cur_req  = req_q[int'(cl)*RW +: RW];
  assign zero_req = (cur_req == '0);
  assign skip     = zero_req && (!act_q[cl] || spare_q == '0);
  assign step     = zero_req ? PW'(NSLOTS) : PW'(NSLOTS / int'(cur_req == '0 ? RW'(1) : cur_req));
  assign walk_end = (pos >= PW'(NSLOTS));
  assign pos_slot = pos[SLW-1:0];
  assign last_cl  = (cl == CLW'(NCLIENTS - 1));
  assign take     = (st == S_RES) && !skip && !walk_end && !owned[pos_slot];
  assign rr_next  = (pick == CLW'(NCLIENTS - 1)) ? '0 : pick + CLW'(1);

  always_comb begin
    logic hit;
    hit  = 1'b0;
    pick = rr;
    for (int k = 0; k < NCLIENTS; k++) begin
      int idx;
      idx = (int'(rr) + k) % NCLIENTS;
      if (!hit && act_q[idx]) begin
        pick = CLW'(idx);
        hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) tbl[pos_slot] <= cl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      req_q <= '0;
      act_q <= '0;
      spare_q <= '0;
      cl <= '0;
      rr <= '0;
      pos <= '0;
      slot <= '0;
      owned <= '0;
      done <= 1'b0;
      wr_en <= 1'b0;
      wr_slot <= '0;
      wr_client <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          done <= 1'b0;
          wr_en <= 1'b0;
          if (start) begin
            req_q <= req_cnt;
            act_q <= active;
            spare_q <= spare;
            owned <= '0;
            cl <= '0;
            pos <= '0;
            st <= S_RES;
          end
        end
        S_RES: begin
          if (skip || walk_end) begin
            pos <= '0;
            if (last_cl) begin
              slot <= '0;
              rr <= '0;
              st <= S_FILL;
            end else begin
              cl <= cl + CLW'(1);
            end
          end else if (owned[pos_slot]) begin
            pos <= pos + PW'(1);
          end else begin
            owned[pos_slot] <= 1'b1;
            pos <= pos + step;
            if (zero_req) spare_q <= spare_q - SPW'(1);
          end
        end
        S_FILL: begin
          wr_en <= 1'b1;
          wr_slot <= slot;
          if (owned[slot]) begin
            wr_client <= tbl[slot];
          end else begin
            wr_client <= pick;
            rr <= rr_next;
          end
          if (slot == SLW'(NSLOTS - 1)) st <= S_FIN;
          else slot <= slot + SLW'(1);
        end
        default: begin
          wr_en <= 1'b0;
          done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end

  p_wr_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
  p_slot_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot != '0) |-> ($past(wr_en) && wr_slot == $past(wr_slot) + SLW'(1)));
  p_client_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_client) < NCLIENTS));
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && $past(wr_slot) == SLW'(NSLOTS - 1) && !busy));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_spare_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RES && $past(st == S_RES)) |-> (spare_q <= $past(spare_q)));
  p_inputs_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(req_q) && $stable(act_q)));

endmodule

// File: tb/tb_slot_table_builder.sv
module tb_slot_table_builder;
  localparam int N = 4;
  localparam int NS = 64;
  localparam int RW = 7;
  localparam int CLW = 2;
  localparam int SLW = 6;
  localparam int SPW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*RW-1:0] req_cnt = '0;
  logic [N-1:0] active = '0;
  logic [SPW-1:0] spare = '0;
  logic busy, done, wr_en;
  logic [SLW-1:0] wr_slot;
  logic [CLW-1:0] wr_client;

  slot_table_builder #(.NSLOTS(NS), .NCLIENTS(N), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_cnt(req_cnt), .active(active),
    .spare(spare), .busy(busy), .done(done), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_client(wr_client));

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int m_req [N];
  int m_act [N];
  int m_sp;
  int expt [NS];
  int got [NS];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic model();
    int sp, rr;
    sp = m_sp;
    for (int s = 0; s < NS; s++) expt[s] = -1;
    for (int c = 0; c < N; c++) begin
      int iv, p;
      if (m_req[c] == 0) begin
        if (m_act[c] == 0 || sp <= 0) continue;
        sp--;
        iv = NS;
      end else iv = NS / m_req[c];
      p = 0;
      while (p < NS) begin
        if (expt[p] >= 0) p++;
        else begin expt[p] = c; p += iv; end
      end
    end
    rr = 0;
    for (int s = 0; s < NS; s++) begin
      if (expt[s] < 0) begin
        int first;
        first = rr;
        while (m_act[rr] == 0) begin
          rr = (rr + 1) % N;
          if (rr == first) break;
        end
        expt[s] = rr;
        rr = (rr + 1) % N;
      end
    end
  endtask

  task automatic drive();
    for (int c = 0; c < N; c++) begin
      req_cnt[c*RW +: RW] = RW'(m_req[c]);
      active[c] = m_act[c][0];
    end
    spare = SPW'(m_sp);
  endtask

  task automatic run(input string tag, input bit disturb);
    int nw, bad, first_bad, prev_slot;
    bit order_ok, seen_done, prev_we;
    model();
    @(negedge clk);
    drive();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nw = 0; bad = 0; first_bad = -1; order_ok = 1; seen_done = 0;
    prev_we = 0; prev_slot = -1;
    for (int s = 0; s < NS; s++) got[s] = -1;
    for (int it = 0; it < 2000; it++) begin
      @(negedge clk);
      if (disturb && it == 10) begin
        start = 1'b1;
        req_cnt = '1;
        active = '0;
        spare = '1;
      end
      if (disturb && it == 11) start = 1'b0;
      if (wr_en) begin
        if (int'(wr_slot) != nw) order_ok = 0;
        got[wr_slot] = int'(wr_client);
        nw++;
      end
      if (done) begin
        seen_done = 1;
        check(prev_we && prev_slot == NS - 1 && !busy, "R8 done timing", prev_slot, NS - 1);
        break;
      end
      prev_we = wr_en;
      prev_slot = int'(wr_slot);
    end
    check(seen_done, "R8 done seen", int'(seen_done), 1);
    @(negedge clk);
    check(!done && !busy, "R8 done single pulse", int'(done), 0);
    check(nw == NS, "R7 write count", nw, NS);
    check(order_ok, "R7 write order", int'(order_ok), 1);
    for (int s = 0; s < NS; s++)
      if (got[s] != expt[s]) begin
        if (first_bad < 0) first_bad = s;
        bad++;
      end
    if (first_bad < 0) check(1, tag, 0, 0);
    else check(0, tag, got[first_bad], expt[first_bad]);
  endtask

  task automatic set4(input int r0, r1, r2, r3, a0, a1, a2, a3, sp);
    m_req[0] = r0; m_req[1] = r1; m_req[2] = r2; m_req[3] = r3;
    m_act[0] = a0; m_act[1] = a1; m_act[2] = a2; m_act[3] = a3;
    m_sp = sp;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    check(0, "watchdog", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(!busy, "R1 busy reset", int'(busy), 0);
    check(!done, "R1 done reset", int'(done), 0);
    check(!wr_en, "R1 wr_en reset", int'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);

    set4(4, 0, 0, 0, 1, 1, 0, 0, 0);
    run("R2 spacing single client", 0);
    check(got[16] == 0 && got[48] == 0, "R2 slot 16/48 owner", got[16], 0);
    set4(3, 5, 0, 0, 1, 0, 1, 0, 0);
    run("R2 collision stepping", 0);
    set4(0, 0, 0, 2, 1, 1, 1, 1, 2);
    run("R3 spare budget two", 0);
    check(got[0] == 0 && got[1] == 1 && got[2] == 3, "R3 first slots", got[2], 3);
    set4(0, 0, 0, 0, 1, 1, 1, 1, 0);
    run("R3 zero budget", 0);
    set4(0, 0, 0, 0, 0, 1, 0, 1, 3);
    run("R4 inactive zero clients", 0);
    cnt = 0;
    for (int s = 0; s < NS; s++) if (got[s] == 0 || got[s] == 2) cnt++;
    check(cnt == 0, "R4 inactive owns nothing", cnt, 0);
    set4(0, 0, 0, 0, 0, 0, 0, 0, 5);
    run("R6 no active client", 0);
    check(got[5] == 1 && got[63] == 3, "R6 pointer owner", got[5], 1);
    set4(2, 0, 0, 0, 0, 0, 0, 0, 0);
    run("R6 no active with reservation", 0);
    set4(64, 0, 0, 0, 1, 1, 1, 1, 4);
    run("R10 full table first", 0);
    set4(0, 1, 0, 0, 1, 1, 1, 1, 0);
    run("R10 fresh table after full", 0);
    set4(8, 2, 0, 16, 1, 0, 1, 1, 1);
    run("R9 start during run ignored", 1);

    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < N; c++) begin
        int v;
        v = (r * 3 + c * 5) % 7;
        m_req[c] = (v < 2) ? 0 : (v * v * v) % 65;
        m_act[c] = ((r * 7 + 3) >> c) & 1;
      end
      m_sp = r % 4;
      run("R5 swept pattern", 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule